// File: doc/BRIEF.md
# Vertical Zero-Cluster Refresh Controller

This block models a small dynamic memory array. Every `CLUSTER` consecutive data rows form a group, and each group has one indicator row. That row holds one bit per column. A bit of 1 means the group's segment of that column holds only zeros. Each group also has a dirty flag, which marks its indicators as untrusted. Refresh proceeds one row per tick. Column segments flagged as all zero are not refreshed, and the skipped column-rows are counted so that the savings can be measured.

Writes are cheap. A write stores the row, zeroes the indicator row of its group and marks the group dirty. The indicators are rebuilt later, during the next refresh pass over that group: each column's bits are ORed as its rows are refreshed, and the inverted result is stored at the group's last row.

Reads use a latched copy of one group's indicators. A read in the same group as the latched copy completes in one phase. A read in another group first fetches that group's indicator row, which adds one phase. Columns flagged as zero read back as 0.

Top module: `zero_cluster_refresh`

## Requirements
- R1: After reset the three counters are 0, reqReady is 1 and rspValid is 0. Every group starts dirty with an all-zero indicator row.
- R2: The group of an address is the address shifted right by log2(CLUSTER). With the default CLUSTER=8, rows 0-7 form group 0, rows 8-15 form group 1, and so on.
- R3: An accepted write stores reqWdata in the addressed row, clears its group's indicator row and sets its group's dirty flag. It completes in the accept cycle, and reqReady is 1 in the following cycle.
- R4: A further write to a group that is already dirty changes no indicator state. Only the data row is updated.
- R5: Each refresh tick refreshes exactly one row, in ascending order, wrapping from the last row to row 0. Every column of that row adds 1 to either cntRefreshed or cntSkipped.
- R6: At the first row of a group, refresh reads that group's indicator row, which adds 1 to cntIndReads. Every column whose indicator is 1 is then skipped for all rows of the group.
- R7: When a group is dirty at its first row, the refresh pass ORs each column's data over the group's rows. Data written into the group meanwhile is included in the OR. At the last row, the indicator row becomes the inverse of the OR and the dirty flag clears.
- R8: A read is answered with a one-cycle rspValid pulse. The pulse comes two cycles after acceptance when the latched indicators are valid and belong to the read's group. Otherwise it comes three cycles after acceptance, and cntIndReads rises by 1.
- R9: rspData equals the stored row, with every column whose latched indicator is 1 forced to 0.
- R10: A write into the group whose indicators are latched for reads invalidates that latch, so the next read of that group takes the extra phase. A write into the group being refreshed stops skipping for the group's remaining rows.
- R11: A refresh tick makes reqReady 0 from the next cycle until that row's refresh finishes. A pending refresh is served before any waiting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | log2(ROWS) | Row address |
| reqWdata | input | COLS | Write data |
| reqReady | output | 1 | Request accepted at this edge when reqValid is high |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspData | output | COLS | Read data |
| refreshTick | input | 1 | Request to refresh the next row |
| cntRefreshed | output | CNT_W | Column-rows refreshed |
| cntSkipped | output | CNT_W | Column-rows skipped |
| cntIndReads | output | CNT_W | Indicator-row reads |

## Verification
The bench targets writes that land in a group while its refresh pass is half done. A design that ignores such a write either keeps skipping columns that now hold ones or stores a stale OR, and the skip counts drift from the reference. It also checks read latency across a group change, and again after a write has invalidated the latched group. A design that trusts a stale latch answers one cycle early and may zero data that is really present. Repeated writes to a dirty group and a first pass over a freshly reset array check that the rebuild turns all-zero columns into skips only after a full pass over the group.

// File: rtl/zcr_pkg.sv
package zcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_IND,
    ST_RD_DATA,
    ST_REF_IND,
    ST_REF_ROW
  } zcrState_t;

  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
    logic rdIndLoad;
    logic rdDataLoad;
    logic refIndLoad;
    logic refRow;
  } zcrStrobes_t;

endpackage

// File: rtl/zcr_ctrl.sv
module zcr_ctrl
  import zcr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        refreshTick,
  input  logic        rdHit,
  input  logic        refBoundary,
  output logic        reqReady,
  output zcrStrobes_t strb
);

  zcrState_t stateQ, stateNext;
  logic      pendingQ;

  assign reqReady = (stateQ == ST_IDLE) && !pendingQ;

  always_comb begin
    stateNext = stateQ;
    strb      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (pendingQ) begin
          stateNext = refBoundary ? ST_REF_IND : ST_REF_ROW;
        end else if (reqValid) begin
          if (reqWrite) begin
            strb.wrAccept = 1'b1;
          end else begin
            strb.rdAccept = 1'b1;
            stateNext     = rdHit ? ST_RD_DATA : ST_RD_IND;
          end
        end
      end
      ST_RD_IND: begin
        strb.rdIndLoad = 1'b1;
        stateNext      = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        strb.rdDataLoad = 1'b1;
        stateNext       = ST_IDLE;
      end
      ST_REF_IND: begin
        strb.refIndLoad = 1'b1;
        stateNext       = ST_REF_ROW;
      end
      ST_REF_ROW: begin
        strb.refRow = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == ST_REF_ROW) pendingQ <= refreshTick;
      else                      pendingQ <= pendingQ | refreshTick;
    end
  end

  // R11: a tick always blocks requests in the following cycle
  a_r11_tick_blocks_requests: assert property (@(posedge clk) disable iff (!rstN)
    refreshTick |=> !reqReady);

  // R8: a read that missed the latch always passes through the indicator phase
  a_r8_miss_fetches_indicator: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdAccept && !rdHit) |=> strb.rdIndLoad);

endmodule

// File: rtl/zcr_datapath.sv
module zcr_datapath
  import zcr_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int COLS    = 8,
  parameter int CLUSTER = 8,
  parameter int CNT_W   = 32,
  localparam int AW     = $clog2(ROWS),
  localparam int LG     = $clog2(CLUSTER),
  localparam int GROUPS = ROWS / CLUSTER,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  zcrStrobes_t      strb,
  input  logic [AW-1:0]    reqAddr,
  input  logic [COLS-1:0]  reqWdata,
  output logic             rdHit,
  output logic             refBoundary,
  output logic             rspValid,
  output logic [COLS-1:0]  rspData,
  output logic [CNT_W-1:0] cntRefreshed,
  output logic [CNT_W-1:0] cntSkipped,
  output logic [CNT_W-1:0] cntIndReads
);

  function automatic logic [GW-1:0] grpOf(input logic [AW-1:0] a);
    logic [AW-1:0] s;
    s = a >> LG;
    return s[GW-1:0];
  endfunction

  logic [COLS-1:0] memQ [ROWS];
  logic [COLS-1:0] indQ [GROUPS];
  logic [GROUPS-1:0] dirtyQ;

  logic [AW-1:0]   addrQ;
  logic [GW-1:0]   rdGrpQ;
  logic [COLS-1:0] rdLatchQ;
  logic            rdValidQ;

  logic [AW-1:0]   refPtrQ;
  logic [GW-1:0]   refGrpQ;
  logic [COLS-1:0] refMaskQ;
  logic [COLS-1:0] accQ;
  logic            accActQ;

  logic [GW-1:0]   reqGrp, addrGrp, ptrGrp;
  logic            refLast;
  logic [COLS-1:0] accNext;
  logic [CNT_W-1:0] skipNow;

  assign reqGrp      = grpOf(reqAddr);
  assign addrGrp     = grpOf(addrQ);
  assign ptrGrp      = grpOf(refPtrQ);
  assign refBoundary = (refPtrQ[LG-1:0] == '0);
  assign refLast     = &refPtrQ[LG-1:0];
  assign accNext     = accQ | memQ[refPtrQ];
  assign skipNow     = CNT_W'($countones(refMaskQ));
  assign rdHit       = rdValidQ && (rdGrpQ == reqGrp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) memQ[r] <= '0;
      for (int g = 0; g < GROUPS; g++) indQ[g] <= '0;
      dirtyQ       <= '1;
      addrQ        <= '0;
      rdGrpQ       <= '0;
      rdLatchQ     <= '0;
      rdValidQ     <= 1'b0;
      refPtrQ      <= '0;
      refGrpQ      <= '0;
      refMaskQ     <= '0;
      accQ         <= '0;
      accActQ      <= 1'b0;
      rspValid     <= 1'b0;
      rspData      <= '0;
      cntRefreshed <= '0;
      cntSkipped   <= '0;
      cntIndReads  <= '0;
    end else begin
      rspValid <= 1'b0;

      if (strb.wrAccept) begin
        memQ[reqAddr]  <= reqWdata;
        indQ[reqGrp]   <= '0;
        dirtyQ[reqGrp] <= 1'b1;
        if (rdValidQ && rdGrpQ == reqGrp) begin
          rdValidQ <= 1'b0;
          rdLatchQ <= '0;
        end
        if (refGrpQ == reqGrp) begin
          refMaskQ <= '0;
          if (accActQ) accQ <= accQ | reqWdata;
        end
      end

      if (strb.rdAccept) addrQ <= reqAddr;

      if (strb.rdIndLoad) begin
        rdLatchQ    <= indQ[addrGrp];
        rdGrpQ      <= addrGrp;
        rdValidQ    <= 1'b1;
        cntIndReads <= cntIndReads + 1'b1;
      end

      if (strb.rdDataLoad) begin
        rspData  <= memQ[addrQ] & ~rdLatchQ;
        rspValid <= 1'b1;
      end

      if (strb.refIndLoad) begin
        refMaskQ    <= indQ[ptrGrp];
        refGrpQ     <= ptrGrp;
        accActQ     <= dirtyQ[ptrGrp];
        accQ        <= '0;
        cntIndReads <= cntIndReads + 1'b1;
      end

      if (strb.refRow) begin
        cntSkipped   <= cntSkipped + skipNow;
        cntRefreshed <= cntRefreshed + CNT_W'(COLS) - skipNow;
        if (accActQ) begin
          accQ <= accNext;
          if (refLast) begin
            indQ[ptrGrp]   <= ~accNext;
            dirtyQ[ptrGrp] <= 1'b0;
            accActQ        <= 1'b0;
          end
        end
        refPtrQ <= (refPtrQ == AW'(ROWS - 1)) ? '0 : refPtrQ + AW'(1);
      end
    end
  end

  // R3: a write leaves its group dirty with a cleared indicator row
  a_r3_write_marks_group: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAccept |=> (dirtyQ[$past(reqGrp)] && indQ[$past(reqGrp)] == '0));

  // R5: each refreshed row accounts for exactly COLS column-rows
  a_r5_row_accounting: assert property (@(posedge clk) disable iff (!rstN)
    strb.refRow |=> ((cntRefreshed + cntSkipped) ==
                     $past(cntRefreshed + cntSkipped) + CNT_W'(COLS)));

  // R7: the last row of a rebuilt group clears its dirty flag
  a_r7_rebuild_clears_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refRow && accActQ && refLast) |=> !dirtyQ[$past(ptrGrp)]);

  // R9: returned data never carries a one in a column flagged as zero
  a_r9_masked_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspData & rdLatchQ) == '0));

  // R10: a write into the latched group drops the latch
  a_r10_write_drops_latch: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrAccept && rdGrpQ == reqGrp) |=> !rdValidQ);

  // R8: a response is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/zero_cluster_refresh.sv
module zero_cluster_refresh
  import zcr_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int COLS    = 8,
  parameter int CLUSTER = 8,
  parameter int CNT_W   = 32,
  localparam int AW     = $clog2(ROWS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqAddr,
  input  logic [COLS-1:0]  reqWdata,
  output logic             reqReady,
  output logic             rspValid,
  output logic [COLS-1:0]  rspData,
  input  logic             refreshTick,
  output logic [CNT_W-1:0] cntRefreshed,
  output logic [CNT_W-1:0] cntSkipped,
  output logic [CNT_W-1:0] cntIndReads
);

  zcrStrobes_t strb;
  logic        rdHit;
  logic        refBoundary;

  zcr_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .refreshTick (refreshTick),
    .rdHit       (rdHit),
    .refBoundary (refBoundary),
    .reqReady    (reqReady),
    .strb        (strb)
  );

  zcr_datapath #(
    .ROWS    (ROWS),
    .COLS    (COLS),
    .CLUSTER (CLUSTER),
    .CNT_W   (CNT_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .rdHit        (rdHit),
    .refBoundary  (refBoundary),
    .rspValid     (rspValid),
    .rspData      (rspData),
    .cntRefreshed (cntRefreshed),
    .cntSkipped   (cntSkipped),
    .cntIndReads  (cntIndReads)
  );

endmodule

// File: tb/test_zero_cluster_refresh.sv
`timescale 1ns/1ps
module test_zero_cluster_refresh;

  localparam int ROWS = 32, COLS = 8, CLUSTER = 8, CNT_W = 32;
  localparam int AW = $clog2(ROWS), LG = $clog2(CLUSTER), GROUPS = ROWS / CLUSTER;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, refreshTick = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [COLS-1:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [COLS-1:0] rspData;
  logic [CNT_W-1:0] cntRefreshed, cntSkipped, cntIndReads;

  always #5 clk = ~clk;

  zero_cluster_refresh #(.ROWS(ROWS), .COLS(COLS), .CLUSTER(CLUSTER), .CNT_W(CNT_W)) i_zero_cluster_refresh (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .refreshTick(refreshTick), .cntRefreshed(cntRefreshed), .cntSkipped(cntSkipped),
    .cntIndReads(cntIndReads));

  int nChecks = 0, nErrors = 0;
  bit finished = 1'b0;

  // reference model state, built from the requirements
  logic [COLS-1:0] mMem [ROWS];
  logic [COLS-1:0] mInd [GROUPS];
  bit mDirty [GROUPS];
  int mPtr, mRefGrp, mRdGrp;
  logic [COLS-1:0] mMask, mAcc, mLatch;
  bit mAccAct, mRdValid;
  longint mRef, mSkip, mIndRd;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int grp(input int a);
    return a >> LG;
  endfunction

  task automatic chkCounters(input string req);
    chk({req, " refreshed"}, longint'(cntRefreshed), mRef);
    chk({req, " skipped"},   longint'(cntSkipped),   mSkip);
    chk({req, " indreads"},  longint'(cntIndReads),  mIndRd);
  endtask

  task automatic doWrite(input int a, input logic [COLS-1:0] d);
    int g;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R3 ready after write", longint'(reqReady), 1);
    g = grp(a);
    mMem[a] = d; mInd[g] = '0; mDirty[g] = 1'b1;
    if (mRdValid && mRdGrp == g) begin mRdValid = 1'b0; mLatch = '0; end
    if (mRefGrp == g) begin
      mMask = '0;
      if (mAccAct) mAcc = mAcc | d;
    end
  endtask

  task automatic doRead(input int a);
    int g, lat, expLat;
    logic [COLS-1:0] expData;
    g = grp(a);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(a);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    if (mRdValid && mRdGrp == g) expLat = 2;
    else begin
      expLat = 3; mIndRd++; mLatch = mInd[g]; mRdGrp = g; mRdValid = 1'b1;
    end
    expData = mMem[a] & ~mLatch;
    chk("R8 read latency", lat, expLat);
    chk("R9 read data", longint'(rspData), longint'(expData));
  endtask

  task automatic doTick();
    int g, pop;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    refreshTick = 1'b1;
    @(negedge clk);
    refreshTick = 1'b0;
    chk("R11 ready low after tick", longint'(reqReady), 0);
    while (!reqReady) @(negedge clk);
    g = grp(mPtr);
    if (mPtr % CLUSTER == 0) begin
      mIndRd++; mMask = mInd[g]; mRefGrp = g; mAccAct = mDirty[g]; mAcc = '0;
    end
    pop = $countones(mMask);
    mSkip += pop; mRef += COLS - pop;
    if (mAccAct) begin
      mAcc = mAcc | mMem[mPtr];
      if (mPtr % CLUSTER == CLUSTER - 1) begin
        mInd[g] = ~mAcc; mDirty[g] = 1'b0; mAccAct = 1'b0;
      end
    end
    mPtr = (mPtr + 1) % ROWS;
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int seedDummy, op, a;
    logic [COLS-1:0] d;
    seedDummy = $urandom(32'd20240611);
    for (int r = 0; r < ROWS; r++) mMem[r] = '0;
    for (int g = 0; g < GROUPS; g++) begin mInd[g] = '0; mDirty[g] = 1'b1; end
    mPtr = 0; mRefGrp = 0; mRdGrp = 0; mMask = '0; mAcc = '0; mLatch = '0;
    mAccAct = 1'b0; mRdValid = 1'b0; mRef = 0; mSkip = 0; mIndRd = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", longint'(reqReady), 1);
    chk("R1 rspValid", longint'(rspValid), 0);
    chkCounters("R1");

    // R5/R7: first pass over reset array rebuilds all groups
    for (int i = 0; i < ROWS; i++) doTick();
    chkCounters("R5 first pass");
    // R6: second pass skips every all-zero column
    for (int i = 0; i < ROWS; i++) doTick();
    chk("R6 all skipped", longint'(cntSkipped), longint'(ROWS * COLS));
    chkCounters("R6 second pass");

    // R2/R3/R8/R9: write group 1, reads across groups
    doWrite(9, 8'h05);
    doRead(9);
    doRead(10);
    doRead(0);
    // R4: second write into dirty group
    doWrite(12, 8'h40);
    doRead(12);
    for (int i = 0; i < ROWS; i++) doTick();
    chkCounters("R7 rebuild group1");
    for (int i = 0; i < ROWS; i++) doTick();
    chkCounters("R6 skip after rebuild");

    // R10: write into group under refresh after two rows
    doTick(); doTick();
    doWrite(5, 8'h80);
    for (int i = 0; i < CLUSTER - 2; i++) doTick();
    chkCounters("R10 refresh stops skipping");
    // R10: write into latched group forces a refetch
    doRead(9);
    doWrite(11, 8'h02);
    doRead(9);
    chkCounters("R10 latch invalidated");

    // random mix
    for (int i = 0; i < 600; i++) begin
      op = $urandom_range(0, 9);
      a = $urandom_range(0, ROWS - 1);
      d = COLS'($urandom) & COLS'($urandom) & 8'h1B;
      if (op < 4) doTick();
      else if (op < 6) doWrite(a, d);
      else doRead(a);
      chkCounters("R5 R6 R7 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule